// File: doc/BRIEF.md
# Sequential Signed Multiplier via Magnitudes

This block multiplies two signed two's complement operands of `WIDTH` bits (8 by default) and returns a signed product of twice that width. It takes one multiplier bit per clock. When a start request is accepted, the block notes whether the product will be negative. It then turns each operand into its unsigned magnitude and builds the unsigned product with a shift-and-add loop. At the end it negates the product if the noted sign calls for it.

The product lives in two halves, high and low. On each step the multiplicand magnitude is added into the high half if the current multiplier bit is set. The high half then shifts right, and the adder carry enters at its top. The low half shifts right behind it and takes in the bit that left the high half. The loop always runs all of its steps. A zero operand gets no special path and gives a zero product.

A caller pulses `start` with the operands while `busy` is low. It then waits for the one-cycle `done` pulse, and reads `product`, which stays valid until the next result is written.

Top module: `smag_mult`

## Requirements
- R1: While reset is asserted, and after it is released, `product` reads 0 and `done` and `busy` read 0 until a start is accepted.
- R2: A `start` sampled high on a rising edge while `busy` is low is accepted. `busy` is high for exactly the next WIDTH+1 cycles.
- R3: `done` is high for exactly one cycle, starting on the (WIDTH+1)th rising edge after the edge that accepted the start. That is edge 9 for WIDTH=8. `busy` is low during that cycle.
- R4: When `done` is high, `product` equals the signed product of the accepted operands as a 2·WIDTH-bit two's complement value.
- R5: The product is negative exactly when the operand sign bits differ and neither operand is zero. A zero operand gives a product of 0.
- R6: The most negative operand (0x80 for WIDTH=8) is handled as magnitude 128. -128 × -128 gives 0x4000, and -128 × 127 gives 0xC080.
- R7: `start` and operand changes while `busy` is high are ignored. They do not change the result or the timing of the computation in progress.
- R8: `product` changes only on the edge that raises `done`. It holds its value in every other cycle.
- R9: A `start` in the cycle where `done` is high is accepted, so results can follow each other with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, synchronised internally on release |
| start | input | 1 | Request a multiplication of `op_a` and `op_b` |
| op_a | input | WIDTH | Multiplicand, two's complement |
| op_b | input | WIDTH | Multiplier, two's complement |
| busy | output | 1 | A multiplication is in progress |
| done | output | 1 | One-cycle pulse: `product` has just been updated |
| product | output | 2*WIDTH | Signed product, held between results |

## Verification
A wrong step count or a stuck control state shows at the ports on the very next expected edge. `busy` or `done` then disagrees with the reference cycle count. An error in the add, the carry rotation or the low-half refill stays hidden until `done`, nine cycles after the start. There it shows as a wrong `product` for the operand patterns that exercise that bit. A sign or magnitude fault on the most negative value shows only for pairs that contain it, so those pairs are swept in full against every second operand.

// File: rtl/smag_mult_pkg.sv
package smag_mult_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } ctrl_state_e;

endpackage

// File: rtl/smag_sign_split.sv
// Turns two signed operands into unsigned magnitudes and the product sign.
module smag_sign_split #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] a_mag_o,
  output logic [WIDTH-1:0] b_mag_o,
  output logic             neg_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] a_flip;
  logic [WIDTH-1:0] b_flip;

  always_comb begin
    a_flip  = ~a_i + {{(WIDTH-1){1'b0}}, 1'b1};
    b_flip  = ~b_i + {{(WIDTH-1){1'b0}}, 1'b1};
    // The most negative value maps onto itself, which reads as its unsigned magnitude.
    a_mag_o = a_i[MSB] ? a_flip : a_i;
    b_mag_o = b_i[MSB] ? b_flip : b_i;
    neg_o   = a_i[MSB] ^ b_i[MSB];
  end

endmodule

// File: rtl/smag_ctrl.sv
// Sequencer: load, WIDTH shift-add steps, then one sign-fix cycle.
module smag_ctrl
  import smag_mult_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic fix_o,
  output logic busy_o
);

  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  ctrl_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    load_o  = 1'b0;
    step_o  = 1'b0;
    fix_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          cnt_d   = '0;
          cnt_en  = 1'b1;
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        step_o = 1'b1;
        cnt_en = 1'b1;
        cnt_d  = cnt_q + CW'(1);
        if (cnt_q == LAST) begin
          state_d = ST_FIX;
        end
      end
      ST_FIX: begin
        fix_o   = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);

endmodule

// File: rtl/smag_shift_add.sv
// Unsigned shift-add core with a split high/low accumulator.
module smag_shift_add #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic [2*WIDTH-1:0] raw_o
);

  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q;
  logic [WIDTH-1:0] mplier_q, mplier_d;
  logic [WIDTH-1:0] hi_q, hi_d;
  logic [WIDTH-1:0] lo_q, lo_d;
  logic [WIDTH-1:0] addend;
  logic [WIDTH:0]   sum;
  logic             acc_en;

  always_comb begin
    addend = mplier_q[0] ? mcand_q : '0;
    sum    = {1'b0, hi_q} + {1'b0, addend};
    acc_en = load_i | step_i;
    if (load_i) begin
      hi_d     = '0;
      lo_d     = '0;
      mplier_d = mplier_i;
    end else begin
      // Carry enters the top of the high half; the bit leaving it refills the low half.
      hi_d     = {sum[WIDTH], sum[WIDTH-1:1]};
      lo_d     = {sum[0], lo_q[WIDTH-1:1]};
      mplier_d = {1'b0, mplier_q[WIDTH-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
    end else if (load_i) begin
      mcand_q <= mcand_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= '0;
      lo_q     <= '0;
      mplier_q <= '0;
    end else if (acc_en) begin
      hi_q     <= hi_d;
      lo_q     <= lo_d;
      mplier_q <= mplier_d;
    end
  end

  assign raw_o = PW'({hi_q, lo_q});

endmodule

// File: rtl/smag_mult.sv
module smag_mult #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);

  localparam int PW = 2 * WIDTH;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [WIDTH-1:0] a_mag, b_mag;
  logic             neg_now;
  logic             neg_q;
  logic             load, step, fix;
  logic [PW-1:0]    raw;
  logic [PW-1:0]    fixed;
  logic [PW-1:0]    product_q;
  logic             done_q;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  smag_sign_split #(.WIDTH(WIDTH)) u_split (
    .a_i     (op_a),
    .b_i     (op_b),
    .a_mag_o (a_mag),
    .b_mag_o (b_mag),
    .neg_o   (neg_now)
  );

  smag_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start),
    .load_o  (load),
    .step_o  (step),
    .fix_o   (fix),
    .busy_o  (busy)
  );

  smag_shift_add #(.WIDTH(WIDTH)) u_core (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_i   (load),
    .step_i   (step),
    .mcand_i  (a_mag),
    .mplier_i (b_mag),
    .raw_o    (raw)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      neg_q <= 1'b0;
    end else if (load) begin
      neg_q <= neg_now;
    end
  end

  always_comb begin
    fixed = neg_q ? (~raw + {{(PW-1){1'b0}}, 1'b1}) : raw;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      product_q <= '0;
      done_q    <= 1'b0;
    end else begin
      done_q <= fix;
      if (fix) begin
        product_q <= fixed;
      end
    end
  end

  assign product = product_q;
  assign done    = done_q;

endmodule

// File: rtl/smag_mult_chk.sv
module smag_mult_chk #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [WIDTH-1:0]   op_a,
  input logic [WIDTH-1:0]   op_b,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);

  localparam int RUNLEN = WIDTH + 1;
  localparam int BW     = $clog2(RUNLEN + 2);
  localparam int PW     = 2 * WIDTH;

  logic [BW-1:0] busy_run;
  logic          exp_neg;
  logic          exp_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_run <= '0;
    end else if (busy) begin
      busy_run <= busy_run + BW'(1);
    end else begin
      busy_run <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_neg  <= 1'b0;
      exp_zero <= 1'b0;
    end else if (start && !busy) begin
      exp_neg  <= op_a[WIDTH-1] ^ op_b[WIDTH-1];
      exp_zero <= (op_a == '0) || (op_b == '0);
    end
  end

  // R2
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R2
  busy_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < BW'(RUNLEN)));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && busy_run == BW'(RUNLEN)));

  // R8
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product));

  // R5
  zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exp_zero) |-> (product == '0));

  // R5
  sign_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !exp_zero) |-> (product[PW-1] == exp_neg));

endmodule

bind smag_mult smag_mult_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .start   (start),
  .op_a    (op_a),
  .op_b    (op_b),
  .busy    (busy),
  .done    (done),
  .product (product)
);

// File: tb/smag_mult_test.sv
`timescale 1ns/1ps
module smag_mult_test;

  localparam int W  = 8;
  localparam int PW = 2 * W;
  localparam int LAT = W + 1;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic [W-1:0]  op_a, op_b;
  logic          busy, done;
  logic [PW-1:0] product;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;
  bit finished = 0;

  // reference model state
  int            m_left;
  logic          m_done;
  logic [PW-1:0] m_prod;
  logic [PW-1:0] m_pend;
  int            m_a, m_b;

  smag_mult #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .product(product)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  // Behavioural reference: a countdown of edges and an integer product.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_left = 0; m_done = 0; m_prod = '0; m_pend = '0;
    end else begin
      cyc++;
      m_done = 0;
      if (m_left > 0) begin
        m_left--;
        if (m_left == 0) begin
          m_done = 1;
          m_prod = m_pend;
        end
      end else if (start) begin
        m_a    = $signed(op_a);
        m_b    = $signed(op_b);
        m_pend = PW'(m_a * m_b);
        m_left = LAT;
      end
    end
  end

  // Compare on every clock, away from the active edge.
  always @(negedge clk) begin
    if (!finished) begin
      chk(busy == (m_left > 0), "R2 busy", busy, (m_left > 0));
      chk(done == m_done, "R3 done", done, m_done);
      chk(product == m_prod, m_done ? "R4 product" : "R8 hold", product, m_prod);
      if (m_done && (m_a == 0 || m_b == 0))
        chk(product == '0, "R5 zero", product, 0);
      if (m_done && m_a == -128 && m_b == -128)
        chk(product == 16'h4000, "R6 min*min", product, 16'h4000);
    end
  end

  // Issue one operation and wait for its done cycle (next start lands in it: R9).
  task automatic run_op(input int a, input int b);
    start = 1; op_a = W'(a); op_b = W'(b);
    @(negedge clk);
    start = 0; op_a = 'x; op_b = 'x;
    op_a = W'(~a); op_b = W'(b + 3);
    while (!done) @(negedge clk);
  endtask

  initial begin
    int corner[12] = '{-128, -127, -64, -2, -1, 0, 1, 2, 3, 64, 126, 127};
    int seed = 7;
    rst_n = 0; start = 0; op_a = '0; op_b = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(product == '0 && !done && !busy, "R1 reset", product, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(product == '0 && !done && !busy, "R1 after release", product, 0);

    // R6 explicit extremes
    run_op(-128, 127);
    chk(product == 16'hC080, "R6 min*max", product, 16'hC080);
    run_op(-128, -128);

    // R7: start and operands toggled while busy must be ignored
    start = 1; op_a = 8'd5; op_b = 8'hFD;
    @(negedge clk);
    for (int i = 0; i < W; i++) begin
      start = 1; op_a = W'(i * 37); op_b = W'(i * 11 + 1);
      @(negedge clk);
    end
    start = 0;
    while (!done) @(negedge clk);
    chk(product == 16'hFFF1, "R7 ignore while busy", product, 16'hFFF1);

    // idle gap, then back-to-back sweeps of corner values against every operand (R4, R5, R9)
    repeat (3) @(negedge clk);
    foreach (corner[k]) begin
      for (int b = -128; b < 128; b++) run_op(corner[k], b);
      for (int a = -128; a < 128; a++) run_op(a, corner[k]);
    end
    // pseudo-random pairs
    for (int n = 0; n < 2000; n++) begin
      seed = seed * 1103515245 + 12345;
      run_op((seed >>> 8) % 128 + ((seed & 1) ? -128 : 0), (seed >>> 16) % 256 - 128);
    end
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_900_000;
    finished = 1;
    errors++; checks++;
    $display("FAIL watchdog expired cycle %0d actual=hung expected=finished", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule